// File: doc/BRIEF.md
# Prescaled Interval Timer with Update Interrupt

This block is a free-running up-counter for periodic events. A prescaler divides the clock. Each time the prescaler wraps, the main counter advances by one step. When the counter has reached its reload limit, the next step returns it to zero. That step is an update event, and it raises a sticky status flag. If the interrupt enable is set, the flag drives the interrupt line. The processor can do other work while the timer runs, and it learns of expiry only through the flag or the interrupt line.

The divider value and the reload limit are written into holding registers. They take effect only at an update event. An update event is either a natural wrap or a forced event that software triggers through a dedicated register. A forced event also restarts both counters from zero and sets the flag. This lets software load a new period at once instead of waiting for the old period to run out. Software acknowledges an event by writing zero to the status flag. If the flag is left set, the interrupt line stays asserted.

Top module: `tick_timer`

## Requirements
- R1: After reset, every register reads 0, the interrupt output is low and the counter does not advance.
- R2: With the run bit set, divider value P and reload limit L, the counter advances once every P+1 clock cycles and steps from L back to 0. The flag therefore rises (P+1)*(L+1) cycles after the run bit takes effect.
- R3: A write to the divider (address 5) or the reload limit (address 6) does not change the running period until the next update event. Reading either address returns the value last written.
- R4: Writing a 1 in bit 0 to the event address (3) restarts the prescaler and the counter at 0, loads the held divider and limit, and sets the flag. The event address always reads 0.
- R5: The update flag (status address 2, bit 0) stays set until a write to address 2 with bit 0 equal to 0. A write with bit 0 equal to 1 leaves the flag unchanged.
- R6: The interrupt output equals the update flag AND the enable bit (address 1, bit 0).
- R7: While the run bit (address 0, bit 0) is 0, the counter holds its value. Address 4 reads the live counter value.
- R8: Address 4 is read-only: writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| irq | output | 1 | Update interrupt line |

## Verification
The bench builds the timer with an 8-bit counter and a 4-bit prescaler. With these widths, a full-scale reload of 255 and the largest divider of 15 run to completion within a few hundred cycles, so every width boundary is measured exactly. A table of divider and limit pairs is timed edge by edge from the run edge. The checks then cover delayed loading of the held values, a forced restart while the timer is running, and the way the flag and enable combine onto the interrupt line.

// File: rtl/tmr_pkg.sv
// Package: shared register addresses for the interval timer.
// Assumes a 3-bit register address space.
package tmr_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL = 3'd0,  // bit 0: run
        RA_IEN  = 3'd1,  // bit 0: interrupt enable
        RA_STAT = 3'd2,  // bit 0: update flag, write 0 clears
        RA_EVT  = 3'd3,  // bit 0: force update, reads 0
        RA_CNT  = 3'd4,  // live counter, read-only
        RA_PSC  = 3'd5,  // divider holding register
        RA_ARR  = 3'd6   // reload holding register
    } reg_addr_e;
endpackage

// File: rtl/tmr_prescaler.sv
// Module: clock divider for the interval timer.
// It produces a one-cycle tick every div+1 cycles while run is high.
// It assumes that div changes only in a cycle where the counter is zeroed
// (restart or wrap), so the count never exceeds div.
module tmr_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PSC_W-1:0] div,
    output logic             tick
);
    logic [PSC_W-1:0] pcnt_q;
    logic             at_top;

    // Purpose: detect the last cycle of a division interval.
    always_comb begin
        at_top = (pcnt_q == div);
        tick   = run && !restart && at_top;
    end

    // Purpose: advance the division count, clear it on restart or wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)          pcnt_q <= '0;
        else if (restart)    pcnt_q <= '0;
        else if (run)        pcnt_q <= at_top ? '0 : pcnt_q + 1'b1;
    end

    AST_PSC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q <= div);  // R2
    AST_PSC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pcnt_q == '0));  // R4
endmodule

// File: rtl/tmr_counter.sv
// Module: main up-counter of the interval timer.
// It steps once per prescaler tick. When it is at the limit, the next
// step returns it to 0 and pulses wrap. It assumes that tick is never
// high in a restart cycle.
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic [CNT_W-1:0] count_q;

    // Purpose: flag the step that takes the counter from limit to zero.
    always_comb begin
        wrap  = tick && (count_q == limit);
        count = count_q;
    end

    // Purpose: count ticks, returning to zero on wrap or restart.
    always_ff @(posedge clk) begin
        if (!rst_n)        count_q <= '0;
        else if (restart)  count_q <= '0;
        else if (tick)     count_q <= wrap ? '0 : count_q + 1'b1;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= limit);  // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count_q == '0));  // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(count_q));  // R7
endmodule

// File: rtl/tmr_regs.sv
// Module: register bank of the interval timer.
// It holds the control bits, the held and active divider and limit, and
// the sticky update flag. It decodes the forced-event strobe and builds the
// read mux. It assumes one write per cycle and DATA_W >= PSC_W, CNT_W.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PSC_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  count,
    input  logic              wrap,
    output logic              run,
    output logic              restart,
    output logic [PSC_W-1:0]  psc_act,
    output logic [CNT_W-1:0]  arr_act,
    output logic              irq
);
    logic             run_q, ien_q, flag_q;
    logic [PSC_W-1:0] psc_q, psc_act_q;
    logic [CNT_W-1:0] arr_q, arr_act_q;
    logic             upd, flag_clr;
    logic             unused_wr_hi;

    // Purpose: decode the forced event, the update and the flag clear.
    always_comb begin
        restart  = wr_en && (wr_addr == RA_EVT) && wr_data[0];
        upd      = restart || wrap;
        flag_clr = wr_en && (wr_addr == RA_STAT) && !wr_data[0];
    end

    assign unused_wr_hi = ^wr_data;

    // Purpose: software-written control and holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            ien_q <= 1'b0;
            psc_q <= '0;
            arr_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                RA_CTRL: run_q <= wr_data[0];
                RA_IEN:  ien_q <= wr_data[0];
                RA_PSC:  psc_q <= wr_data[PSC_W-1:0];
                RA_ARR:  arr_q <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Purpose: move the held values into the active set on an update event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_act_q <= '0;
            arr_act_q <= '0;
        end else if (upd) begin
            psc_act_q <= psc_q;
            arr_act_q <= arr_q;
        end
    end

    // Purpose: sticky update flag; setting wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (upd)      flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    // Purpose: read mux, zero-extended to the data width.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_CTRL: rd_data[0] = run_q;
            RA_IEN:  rd_data[0] = ien_q;
            RA_STAT: rd_data[0] = flag_q;
            RA_CNT:  rd_data[CNT_W-1:0] = count;
            RA_PSC:  rd_data[PSC_W-1:0] = psc_q;
            RA_ARR:  rd_data[CNT_W-1:0] = arr_q;
            default: rd_data = '0;
        endcase
    end

    // Purpose: drive the active values, the run bit and the interrupt.
    always_comb begin
        run     = run_q;
        psc_act = psc_act_q;
        arr_act = arr_act_q;
        irq     = flag_q && ien_q;
    end

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(psc_act_q) && $stable(arr_act_q)));  // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);  // R5
    AST_UPD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> flag_q);  // R4
endmodule

// File: rtl/tick_timer.sv
// Module: top of the prescaled interval timer with update interrupt.
// It connects the register bank, the prescaler and the main counter.
// It assumes a synchronous active-low reset and one write per cycle.
module tick_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PSC_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic             run, restart, tick, wrap;
    logic [PSC_W-1:0] psc_act;
    logic [CNT_W-1:0] arr_act, count;

    tmr_regs #(.DATA_W(DATA_W), .PSC_W(PSC_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .count(count), .wrap(wrap),
        .run(run), .restart(restart),
        .psc_act(psc_act), .arr_act(arr_act), .irq(irq)
    );

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
        .div(psc_act), .tick(tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
        .limit(arr_act), .count(count), .wrap(wrap)
    );

    AST_IEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_IEN && !wr_data[0]) |=> !irq);  // R6
endmodule

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
    import tmr_pkg::*;

    localparam int DW = 32;
    localparam int PW = 4;
    localparam int CW = 8;
    localparam int NV = 7;
    // divider, limit, expected cycles from the run edge to the flag
    localparam int VP [NV] = '{0, 0, 2, 3, 1, 0, 15};
    localparam int VA [NV] = '{0, 4, 3, 0, 6, 255, 1};
    localparam int VE [NV] = '{1, 5, 12, 4, 14, 256, 32};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [2:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          irq;
    int            n_chk = 0;
    int            n_bad = 0;

    tick_timer #(.DATA_W(DW), .PSC_W(PW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a negedge; the write lands on the next posedge
    task automatic wr(input reg_addr_e a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = DW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input reg_addr_e a, output int d);
        rd_addr = a; #0.1; d = int'(rd_data);
    endtask

    // counts negedges until the flag reads 1, starting from c0
    task automatic measure(input int c0, output int c);
        int f;
        c = c0;
        rd(RA_STAT, f);
        while (f == 0 && c < 5000) begin
            @(negedge clk); c++;
            rd(RA_STAT, f);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int v, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 7; a++) begin
            rd(reg_addr_e'(a), v); chk("R1 reset reg", v, 0);
        end
        chk("R1 irq low", int'(irq), 0);
        repeat (3) @(negedge clk);
        rd(RA_CNT, v); chk("R1 counter idle", v, 0);

        // R2: table of periods
        for (int i = 0; i < NV; i++) begin
            wr(RA_CTRL, 0); wr(RA_PSC, VP[i]); wr(RA_ARR, VA[i]);
            wr(RA_EVT, 1); wr(RA_STAT, 0); wr(RA_CTRL, 1);
            measure(0, c);
            chk($sformatf("R2 period p=%0d l=%0d", VP[i], VA[i]), c, VE[i]);
            rd(RA_CNT, v); chk("R2 counter back to 0", v, 0);
        end
        wr(RA_CTRL, 0);

        // R3: held values wait for an update
        wr(RA_PSC, 0); wr(RA_ARR, 9); wr(RA_EVT, 1); wr(RA_STAT, 0);
        wr(RA_ARR, 3);
        rd(RA_ARR, v); chk("R3 readback limit", v, 3);
        rd(RA_PSC, v); chk("R3 readback divider", v, 0);
        wr(RA_CTRL, 1);
        measure(0, c); chk("R3 old limit still active", c, 10);
        wr(RA_STAT, 0);
        measure(1, c); chk("R3 new limit after update", c, 4);
        wr(RA_CTRL, 0);

        // R7 / R8: stop holds, counter read-only
        wr(RA_ARR, 200); wr(RA_EVT, 1); wr(RA_STAT, 0); wr(RA_CTRL, 1);
        repeat (4) @(negedge clk);
        wr(RA_CTRL, 0);
        rd(RA_CNT, v); chk("R7 live counter", v, 5);
        repeat (3) @(negedge clk);
        rd(RA_CNT, v); chk("R7 hold while stopped", v, 5);
        wr(RA_CNT, 'h77);
        rd(RA_CNT, v); chk("R8 counter write ignored", v, 5);

        // R4: forced event while running
        wr(RA_CTRL, 1);
        repeat (2) @(negedge clk);
        rd(RA_CNT, v); chk("R4 counting before event", v, 7);
        wr(RA_EVT, 1);
        rd(RA_CNT, v); chk("R4 counter restarted", v, 0);
        rd(RA_STAT, v); chk("R4 flag set by event", v, 1);
        rd(RA_EVT, v); chk("R4 event reads 0", v, 0);
        @(negedge clk);
        rd(RA_CNT, v); chk("R4 counting resumes", v, 1);

        // R5 / R6: flag and interrupt gating
        chk("R6 irq off when disabled", int'(irq), 0);
        wr(RA_IEN, 1);
        chk("R6 irq on when enabled", int'(irq), 1);
        wr(RA_STAT, 1);
        rd(RA_STAT, v); chk("R5 write 1 keeps flag", v, 1);
        repeat (5) @(negedge clk);
        rd(RA_STAT, v); chk("R5 flag sticky", v, 1);
        chk("R6 irq persists", int'(irq), 1);
        wr(RA_STAT, 0);
        rd(RA_STAT, v); chk("R5 write 0 clears", v, 0);
        chk("R6 irq drops", int'(irq), 0);
        wr(RA_CTRL, 0);

        // R1: reset in mid-operation
        wr(RA_PSC, 7); wr(RA_CTRL, 1); wr(RA_EVT, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 7; a++) begin
            rd(reg_addr_e'(a), v); chk("R1 reset clears reg", v, 0);
        end
        chk("R1 irq low after reset", int'(irq), 0);
        summary();
    end
endmodule